// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame should be kept, looking only at its 48-bit destination address. The six address bytes arrive one per cycle, in wire order. A start strobe marks the first byte. While the bytes stream in, the filter does three things at once:

- It compares the address against ten programmable station addresses.
- It works out the multicast and broadcast properties of the address.
- It runs a bit-serial CRC that later selects one bit of a 64-bit multicast hash table.

Once the sixth byte is in, the filter combines these results with five control inputs (station-address enable, hash enable, all-multicast, promiscuous and broadcast reject). It registers an accept flag and three classification flags, which stay stable until the next frame starts.

A host loads the station addresses and the hash table through a byte-wide write port. The station addresses are packed end to end in one 60-byte region. The hash table sits in an 8-byte region at address 64.

Top module: `da_filter`

## Requirements
- R1: After reset, resultValid, accept, iaMatch, isMulticast and isBroadcast are all 0.
- R2: A byte with daStart and daValid both high begins a new address. Taking it drops resultValid and clears all result flags on the same edge, even if an earlier address was only partly received. The edge after the sixth byte is taken loads the results and sets resultValid. The results then hold until the next start.
- R3: Station address i, byte j is written at configuration address 6*i+j and is compared with the j-th received byte. An address may cross an 8-byte boundary. Address 0 is always compared.
- R4: Station addresses 1 to 9 can produce a hit only while iaEnable is 1.
- R5: isMulticast is bit 0 of the first received byte. isBroadcast is 1 only when all 48 address bits are 1.
- R6: A broadcast address is accepted when bcastReject is 0 and rejected when it is 1, even if a station address matches it.
- R7: A non-multicast address with no station-address hit is accepted only when promiscuous is 1.
- R8: A non-broadcast multicast address is accepted when allMulticast is 1.
- R9: The hash CRC runs as follows:
  - It starts at 0xFFFFFFFF and takes each byte least-significant bit first.
  - At each step the feedback is CRC bit 31 XOR the data bit, and the CRC shifts left by one.
  - When the feedback is 1, the CRC is XORed with 0x04C11DB6 and bit 0 is then set.
  - After 48 bits, index bit k is CRC bit 31-k, for k from 0 to 5.
  - Table bit n is stored at configuration address 64+n/8, bit n%8.
  - A non-broadcast multicast address whose indexed bit is 1 is accepted only while hashEnable is 1.
- R10: A daValid byte without daStart, arriving after the sixth byte or before any start, changes no output. Idle cycles between address bytes are allowed.
- R11: iaMatch is 1 when station address 0, or an enabled station address 1 to 9, equals the received address. A non-broadcast address with such a hit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 7 | Configuration byte address |
| cfgWrData | input | 8 | Configuration write data |
| iaEnable | input | 1 | Let station addresses 1 to 9 take part |
| hashEnable | input | 1 | Enable the multicast hash check |
| allMulticast | input | 1 | Accept every multicast address |
| promiscuous | input | 1 | Accept every non-multicast address |
| bcastReject | input | 1 | Reject broadcast addresses |
| daStart | input | 1 | Marks the first address byte |
| daValid | input | 1 | Address byte valid |
| daByte | input | 8 | Address byte, in wire order |
| resultValid | output | 1 | Results below are valid |
| accept | output | 1 | Frame accepted |
| iaMatch | output | 1 | A station address matched |
| isMulticast | output | 1 | Group address |
| isBroadcast | output | 1 | All-ones address |

## Verification
The assertions take four things for granted about the inputs:
- daStart is meaningful only together with daValid.
- The five control inputs stay unchanged from the sixth byte until the decision edge.
- Configuration writes do not happen while an address is being received.
- The tables are not rewritten while an address is in flight.

The stimulus respects all of these. It drives inputs on the falling edge and changes controls and tables only between frames. It still starts frames in the middle of an address, leaves idle gaps between bytes, and keeps driving valid bytes after the sixth.

// File: rtl/da_filter_pkg.sv
package da_filter_pkg;

  parameter int unsigned STB_IDX_W = 4;
  parameter logic [31:0] HASH_POLY = 32'h04C11DB6;

  typedef struct packed {
    logic                 first;
    logic                 take;
    logic                 decide;
    logic [STB_IDX_W-1:0] idx;
  } strobe_t;

  // One byte of the serial hash CRC, least-significant bit first.
  function automatic logic [31:0] hashCrcByte(input logic [31:0] crcIn, input logic [7:0] dataIn);
    logic [31:0] c;
    logic fb;
    c = crcIn;
    for (int k = 0; k < 8; k++) begin
      fb = c[31] ^ dataIn[k];
      c  = {c[30:0], 1'b0};
      if (fb) c = (c ^ HASH_POLY) | 32'h1;
    end
    return c;
  endfunction

endpackage

// File: rtl/da_filter_ctrl.sv
module da_filter_ctrl
  import da_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    daStart,
  input  logic    daValid,
  output strobe_t stb
);

  localparam logic [STB_IDX_W-1:0] LAST = STB_IDX_W'(ADDR_BYTES);

  logic [STB_IDX_W-1:0] cnt;
  logic busy;
  logic startHit;

  assign startHit = daStart & daValid;

  always_comb begin
    stb.first  = startHit;
    stb.take   = daValid & (startHit | (busy & (cnt < LAST)));
    stb.idx    = startHit ? '0 : cnt;
    stb.decide = busy & ~startHit & (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (startHit) begin
      cnt  <= STB_IDX_W'(1);
      busy <= 1'b1;
    end else if (stb.decide) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (stb.take) begin
      cnt  <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN) cnt <= LAST);
  assert_restart_R2:   assert property (@(posedge clk) disable iff (!rstN)
                          startHit |=> (busy && cnt == STB_IDX_W'(1)));

endmodule

// File: rtl/da_filter_datapath.sv
module da_filter_datapath
  import da_filter_pkg::*;
#(
  parameter int NUM_IA     = 10,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 64,
  parameter int CFG_AW     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        daByte,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic              iaEnable,
  input  logic              hashEnable,
  input  logic              allMulticast,
  input  logic              promiscuous,
  input  logic              bcastReject,
  output logic              resultValid,
  output logic              accept,
  output logic              iaMatch,
  output logic              isMulticast,
  output logic              isBroadcast
);

  localparam int IA_BYTES   = NUM_IA * ADDR_BYTES;
  localparam int IA_AW      = $clog2(IA_BYTES);
  localparam int HASH_BYTES = HASH_BITS / 8;
  localparam int HB_W       = $clog2(HASH_BYTES);
  localparam int HASH_BASE  = 2 ** IA_AW;
  localparam int HIDX_W     = $clog2(HASH_BITS);
  localparam logic [CFG_AW-HB_W-1:0] HASH_PAGE = (CFG_AW-HB_W)'(HASH_BASE / HASH_BYTES);
  localparam logic [STB_IDX_W-1:0] LAST = STB_IDX_W'(ADDR_BYTES);

  // configuration storage
  logic [7:0]           iaMem [IA_BYTES];
  logic [HASH_BITS-1:0] hashMem;
  logic                 iaWrSel, hashWrSel;
  logic [IA_AW-1:0]     iaWrIdx;
  logic [HB_W-1:0]      hashWrIdx;

  assign iaWrSel   = cfgWrEn && (32'(cfgAddr) < 32'(IA_BYTES));
  assign hashWrSel = cfgWrEn && (cfgAddr[CFG_AW-1:HB_W] == HASH_PAGE);
  assign iaWrIdx   = cfgAddr[IA_AW-1:0];
  assign hashWrIdx = cfgAddr[HB_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < IA_BYTES; a++) iaMem[a] <= '0;
    end else if (iaWrSel) begin
      iaMem[iaWrIdx] <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hashMem <= '0;
    end else if (hashWrSel) begin
      for (int b = 0; b < HASH_BYTES; b++)
        if (hashWrIdx == HB_W'(b)) hashMem[b*8 +: 8] <= cfgWrData;
    end
  end

  // per-byte comparison against every station address
  logic [STB_IDX_W-1:0] byteSel;
  logic [NUM_IA-1:0]    byteEq;
  logic [NUM_IA-1:0]    matchVec;

  assign byteSel = (stb.idx < LAST) ? stb.idx : '0;

  for (genvar g = 0; g < NUM_IA; g++) begin : gIa
    logic [IA_AW-1:0] rdIdx;
    assign rdIdx     = IA_AW'(g * ADDR_BYTES) + IA_AW'(byteSel);
    assign byteEq[g] = (iaMem[rdIdx] == daByte);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         matchVec[g] <= 1'b0;
      else if (stb.take) matchVec[g] <= byteEq[g] & (stb.first | matchVec[g]);
    end
  end

  // running address properties and hash CRC
  logic        mcFlag, bcFlag;
  logic [31:0] crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcFlag <= 1'b0;
      bcFlag <= 1'b0;
      crcReg <= '1;
    end else if (stb.take) begin
      if (stb.first) begin
        mcFlag <= daByte[0];
        bcFlag <= &daByte;
        crcReg <= hashCrcByte(32'hFFFF_FFFF, daByte);
      end else begin
        bcFlag <= bcFlag & (&daByte);
        crcReg <= hashCrcByte(crcReg, daByte);
      end
    end
  end

  // decision
  logic [HIDX_W-1:0] hashIdx;
  logic              iaHitNow, hashHitNow, acceptNow;

  always_comb begin
    for (int k = 0; k < HIDX_W; k++) hashIdx[k] = crcReg[31-k];
  end

  assign iaHitNow   = matchVec[0] | (iaEnable & (|matchVec[NUM_IA-1:1]));
  assign hashHitNow = hashEnable & hashMem[hashIdx];

  always_comb begin
    if (bcFlag)      acceptNow = ~bcastReject;
    else if (mcFlag) acceptNow = allMulticast | hashHitNow | iaHitNow;
    else             acceptNow = promiscuous | iaHitNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      accept      <= 1'b0;
      iaMatch     <= 1'b0;
      isMulticast <= 1'b0;
      isBroadcast <= 1'b0;
    end else if (stb.first) begin
      resultValid <= 1'b0;
      accept      <= 1'b0;
      iaMatch     <= 1'b0;
      isMulticast <= 1'b0;
      isBroadcast <= 1'b0;
    end else if (stb.decide) begin
      resultValid <= 1'b1;
      accept      <= acceptNow;
      iaMatch     <= iaHitNow;
      isMulticast <= mcFlag;
      isBroadcast <= bcFlag;
    end
  end

  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rstN)
                            $rose(resultValid) |-> $past(stb.decide));
  assert_hold_R2:         assert property (@(posedge clk) disable iff (!rstN)
                            (resultValid && !stb.first) |=>
                            (resultValid && $stable({accept, iaMatch, isMulticast, isBroadcast})));
  assert_bc_is_mc_R5:     assert property (@(posedge clk) disable iff (!rstN)
                            (resultValid && isBroadcast) |-> isMulticast);
  assert_bc_reject_R6:    assert property (@(posedge clk) disable iff (!rstN)
                            ($rose(resultValid) && isBroadcast && $past(bcastReject)) |-> !accept);
  assert_unicast_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
                            ($rose(resultValid) && !isMulticast && !iaMatch && !$past(promiscuous)) |-> !accept);

endmodule

// File: rtl/da_filter.sv
module da_filter
  import da_filter_pkg::*;
#(
  parameter  int NUM_IA     = 10,
  parameter  int ADDR_BYTES = 6,
  parameter  int HASH_BITS  = 64,
  localparam int CFG_AW     = $clog2(NUM_IA * ADDR_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic              iaEnable,
  input  logic              hashEnable,
  input  logic              allMulticast,
  input  logic              promiscuous,
  input  logic              bcastReject,
  input  logic              daStart,
  input  logic              daValid,
  input  logic [7:0]        daByte,
  output logic              resultValid,
  output logic              accept,
  output logic              iaMatch,
  output logic              isMulticast,
  output logic              isBroadcast
);

  strobe_t stb;

  da_filter_ctrl #(.ADDR_BYTES(ADDR_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .daStart(daStart), .daValid(daValid), .stb(stb)
  );

  da_filter_datapath #(
    .NUM_IA(NUM_IA), .ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .CFG_AW(CFG_AW)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .daByte(daByte),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .iaEnable(iaEnable), .hashEnable(hashEnable), .allMulticast(allMulticast),
    .promiscuous(promiscuous), .bcastReject(bcastReject),
    .resultValid(resultValid), .accept(accept), .iaMatch(iaMatch),
    .isMulticast(isMulticast), .isBroadcast(isBroadcast)
  );

endmodule

// File: tb/sim_da_filter.sv
`timescale 1ns/1ps
module sim_da_filter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [6:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic iaEnable = 1'b0, hashEnable = 1'b0, allMulticast = 1'b0, promiscuous = 1'b0, bcastReject = 1'b0;
  logic daStart = 1'b0, daValid = 1'b0;
  logic [7:0] daByte = '0;
  logic resultValid, accept, iaMatch, isMulticast, isBroadcast;

  always #2.5 clk = ~clk;

  da_filter u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .iaEnable(iaEnable), .hashEnable(hashEnable), .allMulticast(allMulticast),
    .promiscuous(promiscuous), .bcastReject(bcastReject),
    .daStart(daStart), .daValid(daValid), .daByte(daByte),
    .resultValid(resultValid), .accept(accept), .iaMatch(iaMatch),
    .isMulticast(isMulticast), .isBroadcast(isBroadcast)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural reference model
  logic [7:0] mIa [60];
  bit   mHash [64];
  logic [7:0] q [$];
  bit mBusy = 1'b0;
  logic [4:0] expOut = '0;   // {resultValid, accept, iaMatch, isMulticast, isBroadcast}

  function automatic int hashIndexOf(input logic [47:0] v);
    logic [31:0] crc = 32'hFFFF_FFFF;
    int idx = 0;
    for (int j = 0; j < 6; j++) begin
      logic [7:0] cur = v[47-8*j -: 8];
      for (int k = 0; k < 8; k++) begin
        bit fb = crc[31] ^ cur[k];
        crc = crc << 1;
        if (fb) crc = (crc ^ 32'h04C11DB6) | 32'h1;
      end
    end
    for (int k = 0; k < 6; k++) if (crc[31-k]) idx += (1 << k);
    return idx;
  endfunction

  task automatic modelDecide();
    logic [47:0] v = '0;
    bit mc, bc, hit, acc;
    for (int j = 0; j < 6; j++) v[47-8*j -: 8] = q[j];
    mc = q[0][0];
    bc = (v == 48'hFFFF_FFFF_FFFF);
    hit = 1'b0;
    for (int i = 0; i < 10; i++) begin
      bit eq = 1'b1;
      for (int j = 0; j < 6; j++) if (mIa[6*i+j] != q[j]) eq = 1'b0;
      if (eq && (i == 0 || iaEnable)) hit = 1'b1;
    end
    if (bc) acc = !bcastReject;
    else if (mc) acc = allMulticast || hit || (hashEnable && mHash[hashIndexOf(v)]);
    else acc = promiscuous || hit;
    expOut = {1'b1, acc, hit, mc, bc};
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mBusy = 1'b0; expOut = '0;
    end else if (daStart && daValid) begin
      q.delete(); q.push_back(daByte); mBusy = 1'b1; expOut = '0;
    end else if (mBusy && q.size() == 6) begin
      modelDecide(); mBusy = 1'b0;
    end else if (mBusy && daValid) begin
      q.push_back(daByte);
    end
  end

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {resultValid, accept, iaMatch, isMulticast, isBroadcast};
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) if (rstN && !finished) chk("R2 per-cycle", outs(), expOut);

  task automatic cfgWrite(input int addr, input logic [7:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 7'(addr); cfgWrData = data;
    if (addr < 60) mIa[addr] = data;
    else if (addr >= 64 && addr < 72) for (int b = 0; b < 8; b++) mHash[(addr-64)*8+b] = data[b];
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setIa(input int i, input logic [47:0] v);
    for (int j = 0; j < 6; j++) cfgWrite(6*i+j, v[47-8*j -: 8]);
  endtask

  task automatic sendDa(input logic [47:0] v, input int gap);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      daValid = 1'b1; daStart = (j == 0); daByte = v[47-8*j -: 8];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        daValid = 1'b0; daStart = 1'b0;
      end
    end
    @(negedge clk);
    daValid = 1'b0; daStart = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [47:0] IA0 = 48'h02_11_22_33_44_55;
  localparam logic [47:0] IA1 = 48'h02_66_77_88_99_AA;
  localparam logic [47:0] IA3 = 48'h02_AB_CD_EF_01_23;
  localparam logic [47:0] UNI = 48'h04_00_00_00_00_07;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC  = 48'h01_00_5E_00_00_01;

  initial begin
    for (int a = 0; a < 60; a++) mIa[a] = '0;
    for (int b = 0; b < 64; b++) mHash[b] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", outs(), 5'b00000);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", outs(), 5'b00000);

    setIa(0, IA0);
    setIa(1, IA1);
    setIa(3, IA3);

    sendDa(IA0, 0);
    chk("R3 R11 station 0 hit", outs(), 5'b11100);
    sendDa(IA1, 0);
    chk("R4 station 1 disabled", outs(), 5'b10000);
    sendDa(IA3, 0);
    chk("R4 station 3 disabled", outs(), 5'b10000);
    @(negedge clk); iaEnable = 1'b1;
    sendDa(IA1, 0);
    chk("R3 R4 station 1 crossing boundary", outs(), 5'b11100);
    sendDa(IA3, 0);
    chk("R4 R11 station 3 enabled", outs(), 5'b11100);

    sendDa(UNI, 0);
    chk("R7 unknown unicast dropped", outs(), 5'b10000);
    @(negedge clk); promiscuous = 1'b1;
    sendDa(UNI, 0);
    chk("R7 promiscuous accepts", outs(), 5'b11000);
    @(negedge clk); promiscuous = 1'b0;

    sendDa(BC, 0);
    chk("R5 R6 broadcast accepted", outs(), 5'b11011);
    setIa(2, BC);
    @(negedge clk); bcastReject = 1'b1;
    sendDa(BC, 0);
    chk("R6 broadcast rejected over station hit", outs(), 5'b10111);
    @(negedge clk); bcastReject = 1'b0;

    sendDa(MC, 0);
    chk("R5 multicast dropped", outs(), 5'b10010);
    @(negedge clk); allMulticast = 1'b1;
    sendDa(MC, 0);
    chk("R8 all-multicast accepts", outs(), 5'b11010);
    @(negedge clk); allMulticast = 1'b0;
    begin
      int hi = hashIndexOf(MC);
      cfgWrite(64 + hi/8, 8'(1 << (hi % 8)));
    end
    sendDa(MC, 0);
    chk("R9 hash bit set but hash disabled", outs(), 5'b10010);
    @(negedge clk); hashEnable = 1'b1;
    sendDa(MC, 0);
    chk("R9 hash hit accepts", outs(), 5'b11010);
    sendDa(48'h01_00_5E_7F_00_09, 0);

    // R2: restart in the middle of an address
    @(negedge clk); daValid = 1'b1; daStart = 1'b1; daByte = 8'h04;
    @(negedge clk); daStart = 1'b0; daByte = 8'h11;
    @(negedge clk); daByte = 8'h22;
    @(negedge clk); daValid = 1'b0;
    chk("R2 partial address clears result", outs(), 5'b00000);
    sendDa(IA0, 0);
    chk("R2 restart then station 0 hit", outs(), 5'b11100);

    // R10: gaps and trailing bytes
    sendDa(UNI, 2);
    chk("R10 gapped address", outs(), 5'b10000);
    for (int e = 0; e < 10; e++) begin
      @(negedge clk); daValid = 1'b1; daByte = 8'(8'h02 + e);
    end
    @(negedge clk); daValid = 1'b0;
    chk("R10 trailing bytes ignored", outs(), 5'b10000);
    sendDa(IA3, 1);
    chk("R10 R11 gapped station hit", outs(), 5'b11100);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule